// File: doc/BRIEF.md
# Three-Instruction Stored-Program Processor

A very small processor whose program and data share one word-addressed memory. A control state machine takes every instruction through a fixed series of phases. It first presents the instruction pointer to the memory. It then waits one cycle for the synchronous read and latches the instruction word. Next it cracks the word and captures the register operands. Last it performs the operation. A load adds one more phase, in which the fetched memory word is written back to a register.

Only three operations do work. One adds two registers into a third. One copies a memory word at an absolute address into a register. One moves the instruction pointer to a target when a register holds a strictly positive signed value. A fourth opcode stops the machine until reset.

Before a run, the memory is filled through a write port while reset is held. One register can be read at a time on a select/data port. The instruction pointer and the current phase are also visible as outputs.

Top module: `tcpu_top`

## Requirements
- R1: A synchronous active-high reset sets the instruction pointer to 0, clears all 16 registers to 0, drives `halted` low and puts the phase at fetch. The phase codes on `phase_o` are: fetch=0, fetch-wait=1, decode=2, execute=3, load write-back=4, halted=5.
- R2: Each instruction passes through the phases fetch, fetch-wait, decode and execute in that order, one clock each. A load then spends one more clock in write-back. An add or a jump therefore takes 4 clocks, a load 5 clocks, and a halt reaches the halted phase on its 3rd clock.
- R3: An instruction word with bits [31:30]=00 adds. Bits [29:26] and [25:22] name the two source registers and bits [21:18] name the destination. The 32-bit sum wraps modulo 2^32 and raises no flag. Register 0 can be written and read like any other register.
- R4: Bits [31:30]=01 load. Bits [29:26] name the destination and bits [15:0] hold the address, of which only the low 8 bits select the word. The register receives that memory word.
- R5: Bits [31:30]=10 jump. Bits [29:26] name the test register and bits [15:0] hold the target. When the register, read as signed two's complement, is greater than zero, the pointer takes the low 8 bits of the target.
- R6: A jump whose test register is zero or negative does not branch. The pointer moves to the next word.
- R7: After an add or a load, the pointer advances by one. It does not change during the fetch, fetch-wait and decode phases.
- R8: Bits [31:30]=11 halt. The machine enters the halted phase, drives `halted` high and stays there until reset. The pointer keeps the address of the halt word and no register changes.
- R9: The write port stores a word at the given address. Instructions and data share this memory, so a load can read an instruction word.
- R10: Reset applied in the middle of a program returns the machine to the state of R1 after one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_we | input | 1 | Memory preload write enable |
| prog_addr | input | 8 | Memory preload word address |
| prog_data | input | 32 | Memory preload word |
| obs_sel | input | 4 | Register index to observe |
| obs_data | output | 32 | Contents of the selected register |
| ip_o | output | 8 | Instruction pointer |
| phase_o | output | 3 | Current control phase code |
| halted | output | 1 | High while the machine is stopped by a halt |

## Verification
The bench builds the block with its default 8-bit memory address, so the 256-word memory is fully addressable. Because the address is 8 bits wide while the instruction field is 16, a jump target of 0x0110 shows that only the low byte is used. Vectors cover a sum that carries out of bit 31, sums of two most-negative values, and jump tests on zero, minus one, the most-negative value and the largest positive value. Directed runs check the exact phase sequence of add and load instructions, a write to register 0, a load of an instruction word, halt persistence and a reset in mid-program.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;

    localparam int WORD_W    = 32;
    localparam int REG_IDX_W = 4;
    localparam int NUM_REGS  = 1 << REG_IDX_W;
    localparam int FIELD_A_W = 16;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_LOAD = 2'b01,
        OP_JUMP = 2'b10,
        OP_HALT = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_FWAIT  = 3'd1,
        PH_DECODE = 3'd2,
        PH_EXEC   = 3'd3,
        PH_WBACK  = 3'd4,
        PH_HALT   = 3'd5
    } phase_e;

    typedef struct packed {
        op_e                    op;
        logic [REG_IDX_W-1:0]   rs_a;   // also load dest / jump test
        logic [REG_IDX_W-1:0]   rs_b;
        logic [REG_IDX_W-1:0]   rdst;
        logic [FIELD_A_W-1:0]   addr;
    } instr_t;

    function automatic instr_t crack(input logic [WORD_W-1:0] w);
        instr_t d;
        d.op   = op_e'(w[31:30]);
        d.rs_a = w[29:26];
        d.rs_b = w[25:22];
        d.rdst = w[21:18];
        d.addr = w[15:0];
        return d;
    endfunction

endpackage

// File: rtl/tcpu_mem.sv
module tcpu_mem #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata <= store[raddr];
    end
endmodule

// File: rtl/tcpu_regfile.sv
module tcpu_regfile #(
    parameter int IW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [IW-1:0] ra_a,
    output logic [DW-1:0] rd_a,
    input  logic [IW-1:0] ra_b,
    output logic [DW-1:0] rd_b,
    input  logic [IW-1:0] ra_o,
    output logic [DW-1:0] rd_o
);
    localparam int N = 1 << IW;

    logic [DW-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
    assign rd_o = regs[ra_o];
endmodule

// File: rtl/tcpu_alu.sv
module tcpu_alu #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] sum,
    output logic          opa_pos
);
    assign sum     = opa + opb;
    assign opa_pos = ~opa[DW-1] & (|opa[DW-2:0]);
endmodule

// File: rtl/tcpu_ctrl.sv
module tcpu_ctrl
    import tcpu_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic [MEM_AW-1:0]    mem_raddr,
    output logic [REG_IDX_W-1:0] rf_ra_a,
    output logic [REG_IDX_W-1:0] rf_ra_b,
    input  logic [WORD_W-1:0]    rf_rd_a,
    input  logic [WORD_W-1:0]    rf_rd_b,
    output logic                 rf_we,
    output logic [REG_IDX_W-1:0] rf_wa,
    output logic [WORD_W-1:0]    rf_wd,
    output logic [MEM_AW-1:0]    ip,
    output phase_e               phase,
    output logic                 halted
);
    localparam logic [MEM_AW-1:0] IP_ONE = MEM_AW'(1);

    logic [WORD_W-1:0] ir_q;
    logic [WORD_W-1:0] opa_q;
    logic [WORD_W-1:0] opb_q;
    instr_t            dec;
    logic [WORD_W-1:0] sum;
    logic              opa_pos;
    logic [MEM_AW-1:0] ip_next_seq;
    logic [MEM_AW-1:0] ip_target;

    assign dec         = crack(ir_q);
    assign ip_next_seq = ip + IP_ONE;
    assign ip_target   = dec.addr[MEM_AW-1:0];

    tcpu_alu #(.DW(WORD_W)) alu_i (
        .opa     (opa_q),
        .opb     (opb_q),
        .sum     (sum),
        .opa_pos (opa_pos)
    );

    assign rf_ra_a   = dec.rs_a;
    assign rf_ra_b   = dec.rs_b;
    assign mem_raddr = (phase == PH_EXEC) ? ip_target : ip;
    assign halted    = (phase == PH_HALT);

    always_comb begin
        rf_we = 1'b0;
        rf_wa = dec.rdst;
        rf_wd = sum;
        if (phase == PH_EXEC && dec.op == OP_ADD) begin
            rf_we = 1'b1;
        end else if (phase == PH_WBACK) begin
            rf_we = 1'b1;
            rf_wa = dec.rs_a;
            rf_wd = mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FETCH;
            ip    <= '0;
            ir_q  <= '0;
            opa_q <= '0;
            opb_q <= '0;
        end else begin
            unique case (phase)
                PH_FETCH:  phase <= PH_FWAIT;
                PH_FWAIT: begin
                    ir_q  <= mem_rdata;
                    phase <= PH_DECODE;
                end
                PH_DECODE: begin
                    opa_q <= rf_rd_a;
                    opb_q <= rf_rd_b;
                    phase <= (dec.op == OP_HALT) ? PH_HALT : PH_EXEC;
                end
                PH_EXEC: begin
                    unique case (dec.op)
                        OP_LOAD: phase <= PH_WBACK;
                        OP_JUMP: begin
                            ip    <= opa_pos ? ip_target : ip_next_seq;
                            phase <= PH_FETCH;
                        end
                        default: begin
                            ip    <= ip_next_seq;
                            phase <= PH_FETCH;
                        end
                    endcase
                end
                PH_WBACK: begin
                    ip    <= ip_next_seq;
                    phase <= PH_FETCH;
                end
                default:   phase <= PH_HALT;
            endcase
        end
    end

    AST_FETCH_THEN_WAIT: assert property (@(posedge clk) disable iff (rst)
        phase == PH_FETCH |=> phase == PH_FWAIT); // R2
    AST_WAIT_THEN_DECODE: assert property (@(posedge clk) disable iff (rst)
        phase == PH_FWAIT |=> phase == PH_DECODE); // R2
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        phase == PH_HALT |=> (phase == PH_HALT && $stable(ip))); // R8
    AST_IP_FROZEN_EARLY: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH || phase == PH_FWAIT || phase == PH_DECODE) |=> $stable(ip)); // R7
    AST_ADD_STEPS_IP: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && dec.op == OP_ADD) |=> ip == $past(ip) + IP_ONE); // R7
    AST_NONPOS_NO_BRANCH: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && dec.op == OP_JUMP && $signed(opa_q) <= 0)
        |=> ip == $past(ip) + IP_ONE); // R6
    AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && dec.op == OP_LOAD) |=> (phase == PH_WBACK && rf_we)); // R4
endmodule

// File: rtl/tcpu_top.sv
module tcpu_top
    import tcpu_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 prog_we,
    input  logic [MEM_AW-1:0]    prog_addr,
    input  logic [WORD_W-1:0]    prog_data,
    input  logic [REG_IDX_W-1:0] obs_sel,
    output logic [WORD_W-1:0]    obs_data,
    output logic [MEM_AW-1:0]    ip_o,
    output logic [2:0]           phase_o,
    output logic                 halted
);
    logic [MEM_AW-1:0]    mem_raddr;
    logic [WORD_W-1:0]    mem_rdata;
    logic [REG_IDX_W-1:0] rf_ra_a;
    logic [REG_IDX_W-1:0] rf_ra_b;
    logic [WORD_W-1:0]    rf_rd_a;
    logic [WORD_W-1:0]    rf_rd_b;
    logic                 rf_we;
    logic [REG_IDX_W-1:0] rf_wa;
    logic [WORD_W-1:0]    rf_wd;
    phase_e               phase;

    tcpu_mem #(.AW(MEM_AW), .DW(WORD_W)) mem_i (
        .clk   (clk),
        .we    (prog_we),
        .waddr (prog_addr),
        .wdata (prog_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    tcpu_regfile #(.IW(REG_IDX_W), .DW(WORD_W)) rf_i (
        .clk  (clk),
        .rst  (rst),
        .we   (rf_we),
        .wa   (rf_wa),
        .wd   (rf_wd),
        .ra_a (rf_ra_a),
        .rd_a (rf_rd_a),
        .ra_b (rf_ra_b),
        .rd_b (rf_rd_b),
        .ra_o (obs_sel),
        .rd_o (obs_data)
    );

    tcpu_ctrl #(.MEM_AW(MEM_AW)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .mem_raddr (mem_raddr),
        .rf_ra_a   (rf_ra_a),
        .rf_ra_b   (rf_ra_b),
        .rf_rd_a   (rf_rd_a),
        .rf_rd_b   (rf_rd_b),
        .rf_we     (rf_we),
        .rf_wa     (rf_wa),
        .rf_wd     (rf_wd),
        .ip        (ip_o),
        .phase     (phase),
        .halted    (halted)
    );

    assign phase_o = phase;
endmodule

// File: tb/tcpu_top_tb.sv
module tcpu_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic [7:0]  prog_addr = '0;
    logic [31:0] prog_data = '0;
    logic [3:0]  obs_sel = '0;
    logic [31:0] obs_data;
    logic [7:0]  ip_o;
    logic [2:0]  phase_o;
    logic        halted;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcpu_top dut_i (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .obs_sel(obs_sel), .obs_data(obs_data),
        .ip_o(ip_o), .phase_o(phase_o), .halted(halted)
    );

    typedef struct packed {
        logic        is_jump;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'd5,        32'd7,        32'd12},
        '{1'b0, 32'hFFFFFFFF, 32'd1,        32'd0},
        '{1'b0, 32'h80000000, 32'h80000000, 32'd0},
        '{1'b0, 32'h12345678, 32'd0,        32'h12345678},
        '{1'b1, 32'd1,        32'd0,        32'd16},
        '{1'b1, 32'd0,        32'd0,        32'd2},
        '{1'b1, 32'hFFFFFFFF, 32'd0,        32'd2},
        '{1'b1, 32'h80000000, 32'd0,        32'd2},
        '{1'b1, 32'h7FFFFFFF, 32'd0,        32'd16}
    };

    function automatic logic [31:0] enc_add(input logic [3:0] a, input logic [3:0] b,
                                            input logic [3:0] d);
        return {2'b00, a, b, d, 18'd0};
    endfunction
    function automatic logic [31:0] enc_ld(input logic [3:0] r, input logic [15:0] ad);
        return {2'b01, r, 10'd0, ad};
    endfunction
    function automatic logic [31:0] enc_jmp(input logic [3:0] r, input logic [15:0] ad);
        return {2'b10, r, 10'd0, ad};
    endfunction
    localparam logic [31:0] HALT_W = 32'hC000_0000;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = a; prog_data = d;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic run(output int cyc);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        while (!halted && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic peek(input logic [3:0] r, output logic [31:0] v);
        obs_sel = r;
        #1;
        v = obs_data;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int cyc;
        logic [31:0] v;
        logic [7:0]  ip_save;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 phase", {29'd0, phase_o}, 32'd0);
        chk("R1 ip", {24'd0, ip_o}, 32'd0);
        chk("R1 halted", {31'd0, halted}, 32'd0);
        peek(4'd0, v);  chk("R1 r0", v, 32'd0);
        peek(4'd15, v); chk("R1 r15", v, 32'd0);

        // Table: R3 add and R5/R6 jump vectors
        for (int i = 0; i < NV; i++) begin
            hold_reset();
            if (!VECS[i].is_jump) begin
                put(8'h40, VECS[i].a);
                put(8'h41, VECS[i].b);
                put(8'd0, enc_ld(4'd1, 16'h0040));
                put(8'd1, enc_ld(4'd2, 16'h0041));
                put(8'd2, enc_add(4'd1, 4'd2, 4'd3));
                put(8'd3, HALT_W);
                run(cyc);
                peek(4'd3, v);
                chk("R3 sum", v, VECS[i].exp);
                peek(4'd1, v);
                chk("R4 loaded", v, VECS[i].a);
                chk("R2 cycles load+load+add+halt", cyc, 17);
                chk("R8 ip at halt", {24'd0, ip_o}, 32'd3);
            end else begin
                put(8'h50, VECS[i].a);
                put(8'd0, enc_ld(4'd4, 16'h0050));
                put(8'd1, enc_jmp(4'd4, 16'h0110));
                put(8'd2, HALT_W);
                put(8'd16, HALT_W);
                run(cyc);
                if (VECS[i].exp == 32'd16)
                    chk("R5 taken target", {24'd0, ip_o}, VECS[i].exp);
                else
                    chk("R6 not taken", {24'd0, ip_o}, VECS[i].exp);
                chk("R2 cycles load+jump+halt", cyc, 12);
            end
        end

        // R2/R7 phase sequence of add then load
        hold_reset();
        put(8'h40, 32'd9);
        put(8'd0, enc_add(4'd0, 4'd0, 4'd5));
        put(8'd1, enc_ld(4'd6, 16'h0040));
        put(8'd2, HALT_W);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk); chk("R2 add ph1", {29'd0, phase_o}, 32'd1);
        chk("R7 ip held fwait", {24'd0, ip_o}, 32'd0);
        @(negedge clk); chk("R2 add ph2", {29'd0, phase_o}, 32'd2);
        @(negedge clk); chk("R2 add ph3", {29'd0, phase_o}, 32'd3);
        @(negedge clk); chk("R2 add ph0", {29'd0, phase_o}, 32'd0);
        chk("R7 ip after add", {24'd0, ip_o}, 32'd1);
        @(negedge clk); chk("R2 ld ph1", {29'd0, phase_o}, 32'd1);
        @(negedge clk); chk("R2 ld ph2", {29'd0, phase_o}, 32'd2);
        @(negedge clk); chk("R2 ld ph3", {29'd0, phase_o}, 32'd3);
        @(negedge clk); chk("R2 ld ph4", {29'd0, phase_o}, 32'd4);
        chk("R7 ip held until wb", {24'd0, ip_o}, 32'd1);
        @(negedge clk); chk("R2 ld ph0", {29'd0, phase_o}, 32'd0);
        chk("R7 ip after load", {24'd0, ip_o}, 32'd2);
        peek(4'd6, v); chk("R4 r6 loaded", v, 32'd9);
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R8 halt phase", {29'd0, phase_o}, 32'd5);
        chk("R8 halted", {31'd0, halted}, 32'd1);

        // R8 sticky halt
        ip_save = ip_o;
        repeat (10) @(negedge clk);
        chk("R8 still halted", {31'd0, halted}, 32'd1);
        chk("R8 ip frozen", {24'd0, ip_o}, {24'd0, ip_save});
        peek(4'd6, v); chk("R8 r6 unchanged", v, 32'd9);

        // R3 register 0 writable
        hold_reset();
        put(8'd0, enc_ld(4'd1, 16'h0040));
        put(8'd1, enc_add(4'd1, 4'd1, 4'd0));
        put(8'd2, HALT_W);
        run(cyc);
        peek(4'd0, v); chk("R3 r0 written", v, 32'd18);

        // R9 load reads an instruction word; R4 uses low 8 bits of a 16-bit field
        hold_reset();
        put(8'd0, enc_ld(4'd5, 16'h0300));
        put(8'd1, HALT_W);
        run(cyc);
        peek(4'd5, v); chk("R9 self load", v, 32'h5400_0300);

        // R10 reset mid-run
        hold_reset();
        put(8'd0, enc_ld(4'd1, 16'h0040));
        put(8'd1, enc_ld(4'd2, 16'h0040));
        put(8'd2, HALT_W);
        @(negedge clk);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        peek(4'd1, v); chk("R10 r1 before reset", v, 32'd9);
        rst = 1'b1;
        @(negedge clk);
        peek(4'd1, v); chk("R10 r1 cleared", v, 32'd0);
        chk("R10 ip cleared", {24'd0, ip_o}, 32'd0);
        chk("R10 phase fetch", {29'd0, phase_o}, 32'd0);
        chk("R10 halted low", {31'd0, halted}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule